// File: doc/BRIEF.md
# Dual-Channel DMA Cycle Scheduler

This block sequences memory-to-memory style DMA transfers for two independent channels that share one bus. Each channel owns a 20-bit source address, a 20-bit destination address, a 16-bit transfer count and a small control word. A peripheral signals readiness on its channel's data-request level. A shared control section decides which ready channel gets the next bus cycle. It then presents that cycle on a request/acknowledge handshake toward memory. Each acknowledged cycle moves one unit: both addresses step up by one and the count steps down by one.

A channel stops in one of two ways. Its count can run out. Or, if the channel is set up to allow it, its external-terminate input can end it. Either way the channel raises its interrupt output and a status flag that records how it stopped. Software reads the status to clear the interrupt. A lock output holds other bus masters off while any active channel has asked for it.

The first channel is index 0 in every two-bit port, and the second channel is index 1.

Top module: `dma2_sched`

## Requirements
- R1: After reset, bus_req, irq[1:0], lock and stat_busy[1:0] are all 0. The tie pointer favours channel index 0.
- R2: A configuration write applies when cfg_we=1, to channel cfg_ch, register cfg_sel: 0=source address, 1=destination address, 2=count (low 16 bits), 3=control. The control bits are: bit0 priority, bit1 terminate-enable, bit2 lock, bit3 start. While bus_req=1 and bus_ack=0, bus_req, bus_ch, bus_src and bus_dst hold steady. bus_src and bus_dst carry the granted channel's current addresses.
- R3: Each cycle acknowledged (bus_req=1 and bus_ack=1 at a clock edge) adds 1 to both of that channel's addresses, modulo 2^20, and takes 1 from its count. When the count reaches zero, the channel goes idle, sets stat_done_cnt and raises irq.
- R4: A cycle is issued for a channel only while it is armed (stat_busy=1) and its drq is high. While neither holds, bus_req stays 0.
- R5: When both channels are ready with different priority bits, the channel whose priority bit is 1 gets every cycle until it is no longer ready.
- R6: When both channels are ready with equal priority, grants alternate strictly between them, starting from whichever channel the pointer favours. The pointer moves only on such a tie.
- R7: With terminate-enable set, ext high on an armed channel that has no cycle in flight ends the channel. It goes idle, sets stat_done_ext, raises irq and issues no further cycles.
- R8: With terminate-enable clear, ext has no effect: the channel stays armed with irq low, and it finishes by count.
- R9: lock is 1 exactly while some armed channel has its lock bit set.
- R10: A pulse on stat_rd clears irq of channel stat_ch. It leaves the done flags as they are.
- R11: Configuration writes to an armed channel are ignored.
- R12: A start with count 0 ends the channel at once, with stat_done_cnt=1, irq=1, and no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Channel selected for the write |
| cfg_sel | input | 2 | Register selected for the write |
| cfg_wdata | input | 20 | Write data |
| stat_rd | input | 1 | Status read strobe, clears that channel's irq |
| stat_ch | input | 1 | Channel whose status is read |
| drq | input | 2 | Per-channel data-request level |
| ext | input | 2 | Per-channel external terminate |
| irq | output | 2 | Per-channel completion interrupt |
| lock | output | 1 | Bus lock |
| stat_busy | output | 2 | Channel armed |
| stat_done_cnt | output | 2 | Channel ended by count |
| stat_done_ext | output | 2 | Channel ended by external terminate |
| bus_req | output | 1 | Bus cycle request |
| bus_ch | output | 1 | Channel owning the current cycle |
| bus_src | output | 20 | Source address of the cycle |
| bus_dst | output | 20 | Destination address of the cycle |
| bus_ack | input | 1 | Bus cycle acknowledge |

## Verification
The bench targets several corner cases:
- A destination address that crosses the top of the 1 MB space. A design that stepped a wider address would emit a value outside 20 bits.
- Equal-priority channels running side by side. If the pointer moved on non-tie grants, or never moved, the grants would not alternate.
- The terminate input, both enabled and disabled. A design that did not gate it with the enable would stop a channel that should finish by count. A design that ignored it would keep issuing cycles.
- Writes to an armed channel and starts with a zero count. Wrong handling of the first would corrupt the live addresses; wrong handling of the second would issue a stray cycle or hang a channel.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

    localparam int CH_N = 2;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_DST  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_CTRL = 2'd3
    } cfg_sel_e;

    localparam int CTRL_PRIO = 0;
    localparam int CTRL_TEN  = 1;
    localparam int CTRL_LOCK = 2;
    localparam int CTRL_GO   = 3;

    typedef struct packed {
        logic lock_en;
        logic term_en;
        logic prio;
    } chan_ctrl_t;

    function automatic chan_ctrl_t unpack_ctrl(input logic [3:0] w);
        chan_ctrl_t c;
        c.prio    = w[CTRL_PRIO];
        c.term_en = w[CTRL_TEN];
        c.lock_en = w[CTRL_LOCK];
        return c;
    endfunction

    // One-hot pick between two ready channels: priority first, then pointer.
    function automatic logic [1:0] pick2(input logic [1:0] elig,
                                         input logic [1:0] prio,
                                         input logic       turn);
        if (elig == 2'b11) begin
            if (prio[0] != prio[1])
                return prio[1] ? 2'b10 : 2'b01;
            return turn ? 2'b10 : 2'b01;
        end
        return elig;
    endfunction

endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
    import dma2_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  cfg_sel_e          wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              drq,
    input  logic              ext,
    input  logic              inflight,
    input  logic              xfer_done,
    input  logic              clr_irq,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic              elig,
    output logic              prio,
    output logic              lock_req,
    output logic              busy,
    output logic              done_cnt,
    output logic              done_ext,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0]  C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0]  C_ZERO = '0;

    logic [CNT_W-1:0] cnt;
    chan_ctrl_t       ctrl;
    logic             wr_ok, go, go_zero, last, term_hit, irq_set;

    assign wr_ok    = wr_en && !busy;
    assign go       = wr_ok && (wr_sel == SEL_CTRL) && wr_data[CTRL_GO];
    assign go_zero  = go && (cnt == C_ZERO);
    assign last     = (cnt == C_ONE);
    assign term_hit = busy && ctrl.term_en && ext && !inflight;
    assign irq_set  = (xfer_done && last) || term_hit || go_zero;

    assign elig     = busy && drq && !(ctrl.term_en && ext);
    assign prio     = ctrl.prio;
    assign lock_req = busy && ctrl.lock_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            src      <= '0;
            dst      <= '0;
            cnt      <= '0;
            ctrl     <= '0;
            busy     <= 1'b0;
            done_cnt <= 1'b0;
            done_ext <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= irq_set || (irq && !clr_irq);
            if (wr_ok) begin
                case (wr_sel)
                    SEL_SRC:  src <= wr_data;
                    SEL_DST:  dst <= wr_data;
                    SEL_CNT:  cnt <= wr_data[CNT_W-1:0];
                    default: begin
                        ctrl <= unpack_ctrl(wr_data[3:0]);
                        if (wr_data[CTRL_GO]) begin
                            done_ext <= 1'b0;
                            done_cnt <= go_zero;
                            busy     <= !go_zero;
                        end
                    end
                endcase
            end
            if (xfer_done) begin
                src <= src + A_ONE;
                dst <= dst + A_ONE;
                cnt <= cnt - C_ONE;
                if (last) begin
                    busy     <= 1'b0;
                    done_cnt <= 1'b1;
                end
            end else if (term_hit) begin
                busy     <= 1'b0;
                done_ext <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma2_arb.sv
module dma2_arb
    import dma2_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] elig,
    input  logic [1:0] prio,
    input  logic       take,
    output logic [1:0] gnt
);

    logic turn;
    logic tie;

    assign gnt = pick2(elig, prio, turn);
    assign tie = (elig == 2'b11) && (prio[0] == prio[1]);

    always_ff @(posedge clk) begin
        if (rst)
            turn <= 1'b0;
        else if (take && tie)
            turn <= gnt[0];
    end

endmodule

// File: rtl/dma2_sched.sv
module dma2_sched
    import dma2_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_ch,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              stat_rd,
    input  logic              stat_ch,
    input  logic [1:0]        drq,
    input  logic [1:0]        ext,
    output logic [1:0]        irq,
    output logic              lock,
    output logic [1:0]        stat_busy,
    output logic [1:0]        stat_done_cnt,
    output logic [1:0]        stat_done_ext,
    output logic              bus_req,
    output logic              bus_ch,
    output logic [ADDR_W-1:0] bus_src,
    output logic [ADDR_W-1:0] bus_dst,
    input  logic              bus_ack
);

    logic [ADDR_W-1:0] ch_src [CH_N];
    logic [ADDR_W-1:0] ch_dst [CH_N];
    logic [CH_N-1:0]   ch_elig, ch_prio, ch_lock;
    logic [CH_N-1:0]   inflight, xfer_done;
    logic [1:0]        gnt;
    logic              take;
    logic              gidx;

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        assign inflight[i]  = bus_req && (bus_ch == 1'(i));
        assign xfer_done[i] = inflight[i] && bus_ack;

        dma2_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (cfg_we && (cfg_ch == 1'(i))),
            .wr_sel    (cfg_sel_e'(cfg_sel)),
            .wr_data   (cfg_wdata),
            .drq       (drq[i]),
            .ext       (ext[i]),
            .inflight  (inflight[i]),
            .xfer_done (xfer_done[i]),
            .clr_irq   (stat_rd && (stat_ch == 1'(i))),
            .src       (ch_src[i]),
            .dst       (ch_dst[i]),
            .elig      (ch_elig[i]),
            .prio      (ch_prio[i]),
            .lock_req  (ch_lock[i]),
            .busy      (stat_busy[i]),
            .done_cnt  (stat_done_cnt[i]),
            .done_ext  (stat_done_ext[i]),
            .irq       (irq[i])
        );
    end

    assign take = !bus_req;
    assign gidx = gnt[1];
    assign lock = |ch_lock;

    dma2_arb u_arb (
        .clk  (clk),
        .rst  (rst),
        .elig (ch_elig),
        .prio (ch_prio),
        .take (take),
        .gnt  (gnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req <= 1'b0;
            bus_ch  <= 1'b0;
            bus_src <= '0;
            bus_dst <= '0;
        end else if (bus_req) begin
            if (bus_ack)
                bus_req <= 1'b0;
        end else if (|gnt) begin
            bus_req <= 1'b1;
            bus_ch  <= gidx;
            bus_src <= ch_src[gidx];
            bus_dst <= ch_dst[gidx];
        end
    end

endmodule

// File: rtl/dma2_sched_chk.sv
module dma2_sched_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              stat_rd,
    input logic              stat_ch,
    input logic [1:0]        ext,
    input logic [1:0]        irq,
    input logic              lock,
    input logic [1:0]        stat_busy,
    input logic [1:0]        stat_done_cnt,
    input logic [1:0]        stat_done_ext,
    input logic              bus_req,
    input logic              bus_ch,
    input logic [ADDR_W-1:0] bus_src,
    input logic [ADDR_W-1:0] bus_dst,
    input logic              bus_ack
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!bus_req && irq == 2'b00 && !lock && stat_busy == 2'b00));

    a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_ch) &&
                                   $stable(bus_src) && $stable(bus_dst)));

    a_r4_issue_only_armed: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> stat_busy[bus_ch]);

    a_r3_irq_with_count_done0: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_done_cnt[0]) |-> irq[0]);

    a_r3_irq_with_count_done1: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_done_cnt[1]) |-> irq[1]);

    a_r7_ext_done_idle0: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_done_ext[0]) |-> (!stat_busy[0] && irq[0]));

    a_r7_ext_done_idle1: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_done_ext[1]) |-> (!stat_busy[1] && irq[1]));

    a_r9_no_lock_when_idle: assert property (@(posedge clk) disable iff (rst)
        (stat_busy == 2'b00) |-> !lock);

    a_r10_read_clears0: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !stat_ch && !cfg_we && !ext[0] && !(bus_req && bus_ack && !bus_ch))
        |=> !irq[0]);

    a_r10_read_clears1: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && stat_ch && !cfg_we && !ext[1] && !(bus_req && bus_ack && bus_ch))
        |=> !irq[1]);

endmodule

bind dma2_sched dma2_sched_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_we        (cfg_we),
    .stat_rd       (stat_rd),
    .stat_ch       (stat_ch),
    .ext           (ext),
    .irq           (irq),
    .lock          (lock),
    .stat_busy     (stat_busy),
    .stat_done_cnt (stat_done_cnt),
    .stat_done_ext (stat_done_ext),
    .bus_req       (bus_req),
    .bus_ch        (bus_ch),
    .bus_src       (bus_src),
    .bus_dst       (bus_dst),
    .bus_ack       (bus_ack)
);

// File: tb/tb_dma2_sched.sv
`timescale 1ns/100ps
module tb_dma2_sched;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic          cfg_ch = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          stat_rd = 1'b0;
    logic          stat_ch = 1'b0;
    logic [1:0]    drq = 2'b00;
    logic [1:0]    ext = 2'b00;
    logic [1:0]    irq, stat_busy, stat_done_cnt, stat_done_ext;
    logic          lock, bus_req, bus_ch;
    logic [AW-1:0] bus_src, bus_dst;
    logic          bus_ack = 1'b0;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  turn_m  = 1'b0;

    dma2_sched dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .stat_rd(stat_rd), .stat_ch(stat_ch), .drq(drq),
        .ext(ext), .irq(irq), .lock(lock), .stat_busy(stat_busy),
        .stat_done_cnt(stat_done_cnt), .stat_done_ext(stat_done_ext),
        .bus_req(bus_req), .bus_ch(bus_ch), .bus_src(bus_src), .bus_dst(bus_dst),
        .bus_ack(bus_ack)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ctrlw(bit pr, bit ten, bit lk, bit go);
        return AW'({go, lk, ten, pr});
    endfunction

    function automatic logic [AW-1:0] inc(logic [AW-1:0] a);
        return a + AW'(1);
    endfunction

    task automatic cfg(input bit ch, input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog(input bit ch, input logic [AW-1:0] s, input logic [AW-1:0] d,
                        input int n, input logic [AW-1:0] c);
        cfg(ch, 2'd0, s);
        cfg(ch, 2'd1, d);
        cfg(ch, 2'd2, AW'(n));
        cfg(ch, 2'd3, c);
    endtask

    task automatic rd_clear(input bit ch);
        @(negedge clk);
        stat_rd = 1'b1; stat_ch = ch;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic serve(input bit ch, input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input int dly, input string req);
        int k = 0;
        while (!bus_req && k < 60) begin
            @(negedge clk);
            k++;
        end
        chk(req, "cycle issued", longint'(bus_req), 1);
        chk(req, "bus_ch", longint'(bus_ch), longint'(ch));
        chk(req, "bus_src", longint'(bus_src), longint'(s));
        chk(req, "bus_dst", longint'(bus_dst), longint'(d));
        for (int j = 0; j < dly; j++) begin
            @(negedge clk);
            chk("R2", "held src", longint'(bus_src), longint'(s));
            chk("R2", "held req", longint'(bus_req), 1);
        end
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
    endtask

    task automatic quiet(input int n, input string req);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            chk(req, "no cycle", longint'(bus_req), 0);
        end
    endtask

    // Both channels armed with drq held; expected grant order computed here.
    task automatic run_pair(input int n0, input int n1, input bit p0, input bit p1,
                            input logic [AW-1:0] s0, input logic [AW-1:0] d0,
                            input logic [AW-1:0] s1, input logic [AW-1:0] d1,
                            input bit rnd);
        int rem[2];
        logic [AW-1:0] es[2], ed[2];
        rem[0] = n0; rem[1] = n1;
        es[0] = s0; es[1] = s1; ed[0] = d0; ed[1] = d1;
        prog(1'b0, s0, d0, n0, ctrlw(p0, 0, 0, 1));
        prog(1'b1, s1, d1, n1, ctrlw(p1, 0, 0, 1));
        @(negedge clk);
        drq = 2'b11;
        while (rem[0] > 0 || rem[1] > 0) begin
            bit w;
            string tag;
            if (rem[0] > 0 && rem[1] > 0) begin
                if (p0 != p1) begin
                    w = p1; tag = "R5";
                end else begin
                    w = turn_m; turn_m = ~w; tag = "R6";
                end
            end else begin
                w = (rem[1] > 0); tag = "R3";
            end
            serve(w, es[w], ed[w], rnd ? int'($urandom_range(0, 3)) : 0, tag);
            es[w] = inc(es[w]); ed[w] = inc(ed[w]); rem[w]--;
        end
        drq = 2'b00;
        chk("R3", "pair busy", longint'(stat_busy), 0);
        chk("R3", "pair done_cnt", longint'(stat_done_cnt), 3);
        chk("R3", "pair irq", longint'(irq), 3);
        rd_clear(1'b0);
        rd_clear(1'b1);
        chk("R10", "pair irq cleared", longint'(irq), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("R1", "reset bus_req", longint'(bus_req), 0);
        chk("R1", "reset irq", longint'(irq), 0);
        chk("R1", "reset lock", longint'(lock), 0);
        chk("R1", "reset busy", longint'(stat_busy), 0);
        rst = 1'b0;

        // Single channel, destination crosses the top of the address space.
        prog(1'b0, 20'h12345, 20'hFFFFE, 3, ctrlw(0, 0, 0, 1));
        chk("R2", "armed after start", longint'(stat_busy[0]), 1);
        @(negedge clk);
        drq[0] = 1'b1;
        serve(1'b0, 20'h12345, 20'hFFFFE, 2, "R2");
        serve(1'b0, 20'h12346, 20'hFFFFF, 0, "R3");
        serve(1'b0, 20'h12347, 20'h00000, 1, "R3");
        chk("R3", "idle after count", longint'(stat_busy[0]), 0);
        chk("R3", "done_cnt", longint'(stat_done_cnt[0]), 1);
        chk("R3", "irq raised", longint'(irq[0]), 1);
        quiet(4, "R4");
        drq[0] = 1'b0;
        rd_clear(1'b0);
        chk("R10", "irq cleared", longint'(irq[0]), 0);
        chk("R10", "done flag kept", longint'(stat_done_cnt[0]), 1);

        // Armed but no request: nothing issued.
        prog(1'b1, 20'h00100, 20'h00200, 2, ctrlw(0, 0, 0, 1));
        quiet(5, "R4");
        chk("R4", "still armed", longint'(stat_busy[1]), 1);
        drq[1] = 1'b1;
        serve(1'b1, 20'h00100, 20'h00200, 0, "R4");
        serve(1'b1, 20'h00101, 20'h00201, 0, "R4");
        drq[1] = 1'b0;
        chk("R3", "ch1 done", longint'(stat_done_cnt[1]), 1);
        rd_clear(1'b1);

        // Tie interleave from the reset pointer, then priority.
        run_pair(3, 3, 0, 0, 20'h01000, 20'h02000, 20'h03000, 20'h04000, 0);
        run_pair(3, 2, 0, 1, 20'h05000, 20'h06000, 20'h07000, 20'h08000, 0);
        run_pair(2, 3, 1, 0, 20'h09000, 20'h0A000, 20'h0B000, 20'h0C000, 1);

        // Lock follows an armed channel with its lock bit.
        prog(1'b1, 20'h00010, 20'h00020, 2, ctrlw(0, 0, 1, 1));
        chk("R9", "lock while armed", longint'(lock), 1);
        drq[1] = 1'b1;
        serve(1'b1, 20'h00010, 20'h00020, 0, "R9");
        serve(1'b1, 20'h00011, 20'h00021, 0, "R9");
        drq[1] = 1'b0;
        chk("R9", "lock released", longint'(lock), 0);
        rd_clear(1'b1);

        // External terminate, enabled.
        prog(1'b0, 20'h00A00, 20'h00B00, 5, ctrlw(0, 1, 0, 1));
        drq[0] = 1'b1;
        serve(1'b0, 20'h00A00, 20'h00B00, 0, "R7");
        serve(1'b0, 20'h00A01, 20'h00B01, 0, "R7");
        drq[0] = 1'b0;
        ext[0] = 1'b1;
        @(negedge clk);
        ext[0] = 1'b0;
        chk("R7", "idle after ext", longint'(stat_busy[0]), 0);
        chk("R7", "done_ext", longint'(stat_done_ext[0]), 1);
        chk("R7", "no done_cnt", longint'(stat_done_cnt[0]), 0);
        chk("R7", "irq on ext", longint'(irq[0]), 1);
        drq[0] = 1'b1;
        quiet(5, "R7");
        drq[0] = 1'b0;
        rd_clear(1'b0);

        // External terminate, disabled: ignored.
        prog(1'b1, 20'h00C00, 20'h00D00, 3, ctrlw(0, 0, 0, 1));
        drq[1] = 1'b1;
        serve(1'b1, 20'h00C00, 20'h00D00, 0, "R8");
        drq[1] = 1'b0;
        ext[1] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8", "still armed", longint'(stat_busy[1]), 1);
        chk("R8", "no irq", longint'(irq[1]), 0);
        drq[1] = 1'b1;
        serve(1'b1, 20'h00C01, 20'h00D01, 0, "R8");
        serve(1'b1, 20'h00C02, 20'h00D02, 0, "R8");
        drq[1] = 1'b0;
        ext[1] = 1'b0;
        chk("R8", "done by count", longint'(stat_done_cnt[1]), 1);
        chk("R8", "no done_ext", longint'(stat_done_ext[1]), 0);
        rd_clear(1'b1);

        // Writes to an armed channel are dropped.
        prog(1'b0, 20'h00500, 20'h00600, 3, ctrlw(0, 0, 0, 1));
        cfg(1'b0, 2'd0, 20'hABCDE);
        cfg(1'b0, 2'd1, 20'h13579);
        cfg(1'b0, 2'd2, 20'd9);
        cfg(1'b0, 2'd3, ctrlw(0, 0, 1, 1));
        chk("R11", "lock bit not taken", longint'(lock), 0);
        drq[0] = 1'b1;
        serve(1'b0, 20'h00500, 20'h00600, 0, "R11");
        serve(1'b0, 20'h00501, 20'h00601, 0, "R11");
        serve(1'b0, 20'h00502, 20'h00602, 0, "R11");
        chk("R11", "count kept", longint'(stat_busy[0]), 0);
        quiet(3, "R11");
        drq[0] = 1'b0;
        rd_clear(1'b0);

        // Start with zero count.
        cfg(1'b1, 2'd2, 20'd0);
        drq[1] = 1'b1;
        cfg(1'b1, 2'd3, ctrlw(0, 0, 0, 1));
        chk("R12", "not armed", longint'(stat_busy[1]), 0);
        chk("R12", "done_cnt", longint'(stat_done_cnt[1]), 1);
        chk("R12", "irq", longint'(irq[1]), 1);
        quiet(4, "R12");
        drq[1] = 1'b0;
        rd_clear(1'b1);

        // Random rounds.
        for (int r = 0; r < 24; r++) begin
            run_pair(int'($urandom_range(1, 6)), int'($urandom_range(1, 6)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     AW'($urandom), AW'($urandom), AW'($urandom), AW'($urandom), 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule